// File: doc/BRIEF.md
# Saturating Receive Error Counter

This block tallies receive symbol errors seen by a physical-layer receiver. On every clock it looks at three flags: a receive-data-valid flag marking valid carrier, a receive-error flag, and a loopback flag. An error counts only when data is valid and the loopback path is not selected. The count goes up by one for each qualifying cycle. It stops at the all-ones value instead of rolling over.

A host reads the count through a one-cycle read strobe. The value on the count output during the strobe cycle is the value read. The counter returns to zero on the next edge, unless a qualifying error lands in that same cycle. In that case it restarts at one, so the error is not lost. An interrupt level rises as soon as the count is above half scale and stays high until a read clears the counter.

Top module: `rx_err_tally`

## Requirements
- R1: Each clock edge at which `rxValid`=1, `rxErr`=1 and `loopMode`=0 adds exactly one to `cntValue`. An error held high for several cycles therefore counts once per cycle.
- R2: With `rxValid`=0, `rxErr` has no effect on `cntValue`.
- R3: With `loopMode`=1, no error is counted, whatever `rxValid` and `rxErr` are.
- R4: After reset `cntValue` is 0x0000 and `irq` is 0.
- R5: At 0xFFFF the count holds at 0xFFFF when more qualifying errors arrive without a read. It never wraps.
- R6: `irq` is 1 exactly when `cntValue` is greater than 0x7FFF. It changes in the same cycle as the count that crosses the threshold, so it is 1 from 0x8000 upward.
- R7: In a cycle with `rdStrobe`=1, `cntValue` shows the value being read. After that edge the count is 0 and `irq` is 0, when no qualifying error occurred in the read cycle.
- R8: When `rdStrobe`=1 and a qualifying error occur in the same cycle, the count after the edge is 1 and the read shows the value before the increment.
- R9: A read in the same cycle as a qualifying error while the counter sits at 0xFFFF also leaves the count at 1, with `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | Receive data valid, marks valid carrier |
| rxErr | input | 1 | Receive symbol error indication |
| loopMode | input | 1 | Loopback mode active, blocks counting |
| rdStrobe | input | 1 | One-cycle register read; clears the count |
| cntValue | output | 16 | Current error count, also the read data |
| irq | output | 1 | Level interrupt, count above half scale |

## Verification
A host read and a qualifying receive error can land on the same clock edge. This is the one race the block must settle. The bench provokes it twice. The first time is at a small count, with `rdStrobe`, `rxValid` and `rxErr` driven together. The second time is at the saturated value 0xFFFF, after a long run of errors. In each case it checks that the count shown during the strobe cycle is the pre-increment value, that the count after the edge is exactly 1, and that `irq` has dropped. It also drives a read alongside an error that loopback or an idle data-valid flag masks, and expects a clean zero.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

  // Strobes passed from control to datapath once per cycle
  typedef struct packed {
    logic clear;    // host read: drop the count
    logic seedOne;  // with clear: a qualifying error arrived in the read cycle
    logic incr;     // add one (never together with clear)
  } cntStrobe_t;

endpackage

// File: rtl/rx_err_ctrl.sv
module rx_err_ctrl
  import rx_err_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxErr,
  input  logic       loopMode,
  input  logic       rdStrobe,
  input  logic       atMax,
  output cntStrobe_t strb
);

  logic errQual;

  // An error is only meaningful during valid carrier and outside loopback
  always_comb errQual = rxValid & rxErr & ~loopMode;

  always_comb begin
    strb         = '0;
    strb.clear   = rdStrobe;
    strb.seedOne = rdStrobe & errQual;
    strb.incr    = ~rdStrobe & errQual & ~atMax;
  end

  // R3: loopback blocks every counting strobe
  p_loop_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    loopMode |-> !(strb.incr || strb.seedOne));

  // R2: no counting without valid data
  p_valid_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> !(strb.incr || strb.seedOne));

  // R5: no increment offered once saturated
  p_no_inc_at_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    atMax |-> !strb.incr);

  // R8: clear and increment are mutually exclusive
  p_clear_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clear && strb.incr));

endmodule

// File: rtl/rx_err_datapath.sv
module rx_err_datapath
  import rx_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strb,
  output logic [CNT_W-1:0] cntQ,
  output logic             irqQ,
  output logic             atMax
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HALF = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntNext;
  logic             irqNext;

  always_comb atMax = (cntQ == CNT_MAX);

  always_comb begin
    cntNext = cntQ;
    if (strb.clear)     cntNext = strb.seedOne ? CNT_ONE : '0;
    else if (strb.incr) cntNext = cntQ + CNT_ONE;
  end

  // Interrupt registered from the next count so it moves with the count
  always_comb irqNext = (cntNext > CNT_HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      irqQ <= 1'b0;
    end else begin
      cntQ <= cntNext;
      irqQ <= irqNext;
    end
  end

  // R1: an increment strobe adds exactly one
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |=> cntQ == $past(cntQ) + CNT_ONE);

  // R5: saturated count holds without a read
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_MAX && !strb.clear) |=> cntQ == CNT_MAX);

  // R6: interrupt level agrees with the count held
  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == (cntQ > CNT_HALF));

  // R7: a plain read leaves zero
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && !strb.seedOne) |=> (cntQ == '0 && !irqQ));

  // R8: read racing an error leaves one
  p_read_race_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && strb.seedOne) |=> cntQ == CNT_ONE);

endmodule

// File: rtl/rx_err_tally.sv
module rx_err_tally
  import rx_err_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxErr,
  input  logic        loopMode,
  input  logic        rdStrobe,
  output logic [15:0] cntValue,
  output logic        irq
);

  localparam int CNT_W = 16;

  cntStrobe_t strb;
  logic       atMax;

  rx_err_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .rxErr    (rxErr),
    .loopMode (loopMode),
    .rdStrobe (rdStrobe),
    .atMax    (atMax),
    .strb     (strb)
  );

  rx_err_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .cntQ  (cntValue),
    .irqQ  (irq),
    .atMax (atMax)
  );

endmodule

// File: tb/rx_err_tally_bench.sv
module rx_err_tally_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic        rxErr = 1'b0;
  logic        loopMode = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [15:0] cntValue;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  rx_err_tally u_rx_err_tally (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxErr(rxErr),
    .loopMode(loopMode), .rdStrobe(rdStrobe), .cntValue(cntValue), .irq(irq)
  );

  // Vector: {valid, err, loop, rd, expected count after the edge [3:0]}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b1100_0001,  // R1 count
    8'b1100_0010,  // R1 held error counts again
    8'b0100_0010,  // R2 error without valid
    8'b1110_0010,  // R3 loopback blocks
    8'b1000_0010,  // valid, no error
    8'b1100_0011,  // R1
    8'b0001_0000,  // R7 read clears
    8'b1100_0001,  // R1
    8'b1101_0001,  // R8 read + error -> 1
    8'b1111_0000,  // R3 R7 read + masked error -> 0
    8'b1100_0001,  // R1
    8'b0101_0000   // R2 R7 read + error without valid -> 0
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic e, logic l, logic r);
    rxValid = v; rxErr = e; loopMode = l; rdStrobe = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] prevExp;
    repeat (3) @(negedge clk);
    check("R4 count at reset", cntValue, 16'h0000);
    check("R4 irq at reset", {15'b0, irq}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk
    prevExp = 16'h0000;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      if (VEC[i][4]) check("R7 R8 read value in table", cntValue, prevExp);
      @(negedge clk);
      check("R1 R2 R3 R7 R8 table step", cntValue, {12'b0, VEC[i][3:0]});
      prevExp = {12'b0, VEC[i][3:0]};
    end
    drive(0, 0, 0, 0);
    @(negedge clk);

    // Ramp to just below threshold (count is 0 here)
    drive(1, 1, 0, 0);
    repeat (32767) @(negedge clk);
    check("R6 count at 0x7FFF", cntValue, 16'h7FFF);
    check("R6 irq low at 0x7FFF", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    check("R6 count at 0x8000", cntValue, 16'h8000);
    check("R6 irq high at 0x8000", {15'b0, irq}, 16'h0001);
    repeat (32767) @(negedge clk);
    check("R5 count reaches 0xFFFF", cntValue, 16'hFFFF);
    repeat (5) @(negedge clk);
    check("R5 holds at 0xFFFF", cntValue, 16'hFFFF);
    check("R6 irq stays high", {15'b0, irq}, 16'h0001);

    // Read racing an error at saturation
    drive(1, 1, 0, 1);
    check("R9 read value at saturation", cntValue, 16'hFFFF);
    @(negedge clk);
    check("R9 count after racing read", cntValue, 16'h0001);
    check("R9 irq after racing read", {15'b0, irq}, 16'h0000);

    // Plain read back to zero
    drive(0, 0, 0, 1);
    @(negedge clk);
    check("R7 cleared", cntValue, 16'h0000);
    drive(0, 0, 0, 0);

    // Reset in mid count
    drive(1, 1, 0, 0);
    repeat (4) @(negedge clk);
    check("R1 count before reset", cntValue, 16'h0004);
    drive(0, 0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R4 count after reset", cntValue, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule